// File: doc/BRIEF.md
# Systolic Local-Alignment Scoring Array

This block scores the best local alignment between a fixed nucleotide query and a streamed database sequence. It uses affine gap costs. A chain of `N_PE` processing elements each holds one query symbol. Each database symbol enters the head of the chain and moves one element further on every advance. Element `j` therefore scores row `i` of the dynamic-programming matrix `j` advances after element 0 did. Each element keeps the score of the cell above it and the left neighbour's score from the previous row, which serves as the diagonal term. The horizontal and vertical gap states travel with those scores.

Each token carries the best cell score of its row so far. The controller folds the token leaving the tail into a whole-matrix maximum. When the token flagged as the end of the sequence leaves the tail, the controller presents that maximum as the result. The query is written one element at a time through a small write port. The database stream uses a valid/ready handshake. A symbol flagged as last starts a flush, and no new symbol is taken until the result has been shown.

Top module: `swa_array`

## Requirements
- R1: After reset, `resValid` is low and `dbReady` is high.
- R2: A write with `qWrEn` high stores `qWrSym` as the query symbol of element `qWrIdx`. Later results use the new symbol.
- R3: Symbol codes are A=0, C=1, G=2, and 3 for both T and U. Codes 4 to 7 are the unknown symbol N. Two equal known codes score +1 and two different known codes score -1. Any pair that includes N scores 0.
- R4: A gap costs 10 for its first symbol and 3 for each further symbol. Gap costs are affine.
- R5: No cell score falls below zero. A database with no symbol in common with the query gives a result of 0.
- R6: The result equals the largest cell of the full local-alignment matrix. In that matrix, the first row and first column are zero.
- R7: A database symbol is taken on a clock edge only when `dbValid` and `dbReady` are both high. Cycles with `dbValid` low do not change the result.
- R8: `dbReady` goes low on the edge that takes a symbol with `dbLast` high. It stays low until the result has been presented. `resValid` is a one-cycle pulse.
- R9: `resValid` goes high exactly `N_PE` clock edges after the edge that took the last symbol. `resScore` changes only on the edge where `resValid` rises.
- R10: Each sequence is scored on its own. The first symbol after a `dbLast` sees zero above it, whatever came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| qWrEn | input | 1 | Query symbol write strobe |
| qWrIdx | input | IDX_W | Element that receives the query symbol |
| qWrSym | input | 3 | Query symbol code |
| dbValid | input | 1 | Database symbol present |
| dbReady | output | 1 | Array can take a database symbol |
| dbSym | input | 3 | Database symbol code |
| dbLast | input | 1 | Marks the final symbol of a sequence |
| resValid | output | 1 | Result pulse |
| resScore | output | 16 | Highest alignment score of the last sequence |

## Verification
The assertions assume that `dbValid` and `dbLast` are driven to defined values on every cycle after reset. The latency and pulse checks also assume that every sequence ends with a symbol flagged `dbLast`. The bench drives the stream at falling edges and holds a symbol only until the edge that takes it. It loads the query only while no sequence is in flight. It never asserts `dbValid` while waiting for a result. Sequences are capped at 64 symbols, so every score stays far below the 16-bit range.

// File: rtl/swa_pkg.sv
package swa_pkg;
  parameter int SYM_W   = 3;
  parameter int SCORE_W = 16;

  localparam logic [SYM_W-1:0] SYM_N = SYM_W'(4);

  typedef logic signed [SCORE_W-1:0] score_t;

  // Stands in for minus infinity at matrix edges; far below any reachable score.
  localparam score_t SCORE_FLOOR = score_t'(-(2 ** (SCORE_W - 2)));

  typedef struct packed {
    logic             valid;
    logic             first;
    logic             last;
    logic [SYM_W-1:0] sym;
    score_t           h;
    score_t           e;
    score_t           best;
  } token_t;

  typedef struct packed {
    logic advance;
    logic inject;
    logic markFirst;
    logic capture;
  } strobe_t;

  function automatic score_t smax(input score_t a, input score_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/swa_pe.sv
module swa_pe
  import swa_pkg::*;
#(
  parameter int MATCH    = 1,
  parameter int MISMATCH = 1,
  parameter int GAP_OPEN = 10,
  parameter int GAP_EXT  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  input  logic [SYM_W-1:0] qSym,
  input  token_t           tokIn,
  output token_t           tokOut
);
  score_t hUp, fUp, diagPrev;
  score_t sub, diag, upH, upF, eNew, fNew, hNew;
  token_t nxt;

  always_comb begin
    if (qSym >= SYM_N || tokIn.sym >= SYM_N) sub = '0;
    else if (qSym == tokIn.sym)              sub = score_t'(MATCH);
    else                                     sub = -score_t'(MISMATCH);

    diag = tokIn.first ? '0 : diagPrev;
    upH  = tokIn.first ? '0 : hUp;
    upF  = tokIn.first ? SCORE_FLOOR : fUp;

    eNew = smax(tokIn.h - score_t'(GAP_OPEN), tokIn.e - score_t'(GAP_EXT));
    fNew = smax(upH - score_t'(GAP_OPEN), upF - score_t'(GAP_EXT));
    hNew = smax(smax('0, diag + sub), smax(eNew, fNew));

    nxt      = tokIn;
    nxt.h    = hNew;
    nxt.e    = eNew;
    nxt.best = smax(tokIn.best, hNew);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tokOut   <= '0;
      hUp      <= '0;
      fUp      <= SCORE_FLOOR;
      diagPrev <= '0;
    end else if (advance) begin
      tokOut <= nxt;
      if (tokIn.valid) begin
        hUp      <= hNew;
        fUp      <= fNew;
        diagPrev <= tokIn.h;
      end
    end
  end
endmodule

// File: rtl/swa_datapath.sv
module swa_datapath
  import swa_pkg::*;
#(
  parameter int N_PE     = 32,
  parameter int MATCH    = 1,
  parameter int MISMATCH = 1,
  parameter int GAP_OPEN = 10,
  parameter int GAP_EXT  = 3,
  parameter int IDX_W    = $clog2(N_PE)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             qWrEn,
  input  logic [IDX_W-1:0] qWrIdx,
  input  logic [SYM_W-1:0] qWrSym,
  input  logic [SYM_W-1:0] dbSym,
  input  logic             dbLast,
  output logic             tailValid,
  output logic             tailLast,
  output score_t           resScore
);
  logic [SYM_W-1:0] qReg [N_PE];
  token_t headTok;
  token_t chain [N_PE];
  score_t acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < N_PE; k++) qReg[k] <= '0;
    end else if (qWrEn && (int'(qWrIdx) < N_PE)) begin
      qReg[qWrIdx] <= qWrSym;
    end
  end

  always_comb begin
    headTok       = '0;
    headTok.valid = strobe.inject;
    headTok.first = strobe.markFirst;
    headTok.last  = dbLast;
    headTok.sym   = dbSym;
    headTok.e     = SCORE_FLOOR;
  end

  for (genvar j = 0; j < N_PE; j++) begin : g_pe
    token_t peIn;
    if (j == 0) begin : g_head
      assign peIn = headTok;
    end else begin : g_link
      assign peIn = chain[j-1];
    end
    swa_pe #(
      .MATCH(MATCH), .MISMATCH(MISMATCH), .GAP_OPEN(GAP_OPEN), .GAP_EXT(GAP_EXT)
    ) u_pe (
      .clk(clk), .rstN(rstN), .advance(strobe.advance),
      .qSym(qReg[j]), .tokIn(peIn), .tokOut(chain[j])
    );
  end

  assign tailValid = chain[N_PE-1].valid;
  assign tailLast  = chain[N_PE-1].last;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      resScore <= '0;
    end else begin
      if (strobe.advance && tailValid)
        acc <= strobe.capture ? '0 : smax(acc, chain[N_PE-1].best);
      if (strobe.capture)
        resScore <= smax(acc, chain[N_PE-1].best);
    end
  end
endmodule

// File: rtl/swa_ctrl.sv
module swa_ctrl
  import swa_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    dbValid,
  input  logic    dbLast,
  input  logic    tailValid,
  input  logic    tailLast,
  output strobe_t strobe,
  output logic    dbReady,
  output logic    resValid
);
  typedef enum logic [1:0] {ST_STREAM, ST_FLUSH, ST_DONE} state_t;

  state_t state, stateNext;
  logic   firstPend;

  always_comb begin
    strobe           = '0;
    strobe.markFirst = firstPend;
    stateNext        = state;
    case (state)
      ST_STREAM: begin
        if (dbValid) begin
          strobe.advance = 1'b1;
          strobe.inject  = 1'b1;
          if (dbLast) stateNext = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        strobe.advance = 1'b1;
        if (tailValid && tailLast) begin
          strobe.capture = 1'b1;
          stateNext      = ST_DONE;
        end
      end
      default: stateNext = ST_STREAM;
    endcase
  end

  assign dbReady  = (state == ST_STREAM);
  assign resValid = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_STREAM;
      firstPend <= 1'b1;
    end else begin
      state <= stateNext;
      if (strobe.inject) firstPend <= dbLast;
    end
  end
endmodule

// File: rtl/swa_array.sv
module swa_array
  import swa_pkg::*;
#(
  parameter int N_PE     = 32,
  parameter int MATCH    = 1,
  parameter int MISMATCH = 1,
  parameter int GAP_OPEN = 10,
  parameter int GAP_EXT  = 3,
  parameter int IDX_W    = $clog2(N_PE)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      qWrEn,
  input  logic [IDX_W-1:0]          qWrIdx,
  input  logic [SYM_W-1:0]          qWrSym,
  input  logic                      dbValid,
  output logic                      dbReady,
  input  logic [SYM_W-1:0]          dbSym,
  input  logic                      dbLast,
  output logic                      resValid,
  output logic signed [SCORE_W-1:0] resScore
);
  strobe_t strobe;
  logic    tailValid, tailLast;

  swa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dbValid(dbValid), .dbLast(dbLast),
    .tailValid(tailValid), .tailLast(tailLast),
    .strobe(strobe), .dbReady(dbReady), .resValid(resValid)
  );

  swa_datapath #(
    .N_PE(N_PE), .MATCH(MATCH), .MISMATCH(MISMATCH),
    .GAP_OPEN(GAP_OPEN), .GAP_EXT(GAP_EXT), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .qWrEn(qWrEn), .qWrIdx(qWrIdx), .qWrSym(qWrSym),
    .dbSym(dbSym), .dbLast(dbLast),
    .tailValid(tailValid), .tailLast(tailLast), .resScore(resScore)
  );
endmodule

// File: rtl/swa_array_chk.sv
module swa_array_chk #(
  parameter int N_PE  = 32,
  parameter int MATCH = 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               dbValid,
  input logic               dbReady,
  input logic               dbLast,
  input logic               resValid,
  input logic signed [15:0] resScore
);
  localparam int AGE_CAP = N_PE + 4;

  int lastAge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastAge <= AGE_CAP;
    else if (dbValid && dbReady && dbLast) lastAge <= 0;
    else if (lastAge < AGE_CAP) lastAge <= lastAge + 1;
  end

  assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);
  assert_no_intake_at_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !dbReady);
  assert_last_stops_intake_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dbValid && dbReady && dbLast) |=> !dbReady);
  assert_fixed_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (lastAge == N_PE));
  assert_score_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resScore) |-> resValid);
  assert_score_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resScore >= 0));
  assert_score_ceiling_R6: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (int'(resScore) <= N_PE * MATCH));
endmodule

bind swa_array swa_array_chk #(.N_PE(N_PE), .MATCH(MATCH)) u_chk (
  .clk(clk), .rstN(rstN), .dbValid(dbValid), .dbReady(dbReady),
  .dbLast(dbLast), .resValid(resValid), .resScore(resScore)
);

// File: tb/sim_swa_array.sv
module sim_swa_array;
  localparam int CLK_PERIOD = 10;
  localparam int NPE        = 32;
  localparam int MAXDB      = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              qWrEn = 1'b0;
  logic [4:0]        qWrIdx = '0;
  logic [2:0]        qWrSym = '0;
  logic              dbValid = 1'b0;
  logic              dbReady;
  logic [2:0]        dbSym = '0;
  logic              dbLast = 1'b0;
  logic              resValid;
  logic signed [15:0] resScore;

  int checks = 0;
  int errors = 0;
  int qArr [NPE];
  int dbArr [MAXDB];

  always #(CLK_PERIOD / 2) clk = ~clk;

  swa_array #(.N_PE(NPE)) u0 (
    .clk(clk), .rstN(rstN), .qWrEn(qWrEn), .qWrIdx(qWrIdx), .qWrSym(qWrSym),
    .dbValid(dbValid), .dbReady(dbReady), .dbSym(dbSym), .dbLast(dbLast),
    .resValid(resValid), .resScore(resScore)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int subScore(input int a, input int b);
    if (a >= 4 || b >= 4) return 0;
    return (a == b) ? 1 : -1;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int refScore(input int len);
    int h [MAXDB+1][NPE+1];
    int e [MAXDB+1][NPE+1];
    int f [MAXDB+1][NPE+1];
    int best = 0;
    for (int i = 0; i <= len; i++) begin
      h[i][0] = 0; e[i][0] = -100000; f[i][0] = -100000;
    end
    for (int j = 0; j <= NPE; j++) begin
      h[0][j] = 0; e[0][j] = -100000; f[0][j] = -100000;
    end
    for (int i = 1; i <= len; i++)
      for (int j = 1; j <= NPE; j++) begin
        e[i][j] = imax(h[i][j-1] - 10, e[i][j-1] - 3);
        f[i][j] = imax(h[i-1][j] - 10, f[i-1][j] - 3);
        h[i][j] = imax(imax(0, h[i-1][j-1] + subScore(dbArr[i-1], qArr[j-1])),
                       imax(e[i][j], f[i][j]));
        best = imax(best, h[i][j]);
      end
    return best;
  endfunction

  task automatic loadQuery();
    for (int k = 0; k < NPE; k++) begin
      @(negedge clk);
      qWrEn = 1'b1; qWrIdx = 5'(k); qWrSym = 3'(qArr[k]);
    end
    @(negedge clk);
    qWrEn = 1'b0;
  endtask

  task automatic writeOne(input int idx, input int sym);
    @(negedge clk);
    qWrEn = 1'b1; qWrIdx = 5'(idx); qWrSym = 3'(sym);
    qArr[idx] = sym;
    @(negedge clk);
    qWrEn = 1'b0;
  endtask

  // Streams dbArr[0..len-1], waits for the result, checks score, latency and intake.
  task automatic runCheck(input string tag, input int len, input bit stall, input int fixedExp);
    int cnt = 0;
    bit readyHigh = 1'b0;
    int expv = refScore(len);
    for (int k = 0; k < len; k++) begin
      if (stall && ($urandom_range(0, 2) == 0)) begin
        @(negedge clk);
        dbValid = 1'b0;
        dbSym = 3'(($urandom_range(0, 3)));
        dbLast = 1'b1;
        @(negedge clk);
      end else begin
        @(negedge clk);
      end
      dbValid = 1'b1; dbSym = 3'(dbArr[k]); dbLast = (k == len - 1);
      @(posedge clk);
    end
    @(negedge clk);
    dbValid = 1'b0; dbLast = 1'b0;
    while (!resValid && cnt < 400) begin
      if (dbReady) readyHigh = 1'b1;
      @(negedge clk);
      cnt++;
    end
    check(resValid == 1'b1, {tag, " R9 result pulse seen"}, int'(resValid), 1);
    check(cnt == NPE, {tag, " R9 latency after last symbol"}, cnt, NPE);
    check(!readyHigh, {tag, " R8 dbReady low while flushing"}, int'(readyHigh), 0);
    check(int'(resScore) == expv, {tag, " R6 score vs reference"}, int'(resScore), expv);
    if (fixedExp >= 0)
      check(int'(resScore) == fixedExp, {tag, " fixed score"}, int'(resScore), fixedExp);
    @(negedge clk);
    check(resValid == 1'b0, {tag, " R8 single-cycle pulse"}, int'(resValid), 0);
  endtask

  task automatic setPeriodicQuery();
    for (int k = 0; k < NPE; k++) qArr[k] = k % 4;
    loadQuery();
  endtask

  task automatic t_reset();
    check(resValid == 1'b0, "R1 resValid after reset", int'(resValid), 0);
    check(dbReady == 1'b1, "R1 dbReady after reset", int'(dbReady), 1);
  endtask

  task automatic t_exact();
    setPeriodicQuery();
    for (int k = 0; k < NPE; k++) dbArr[k] = qArr[k];
    runCheck("R3 exact match", NPE, 1'b0, 32);
  endtask

  task automatic t_wildcard();
    for (int k = 0; k < 20; k++) dbArr[k] = 4;
    runCheck("R3 all N", 20, 1'b0, 0);
    for (int k = 0; k < 12; k++) dbArr[k] = 7;
    runCheck("R3 code 7 as N", 12, 1'b0, 0);
  endtask

  task automatic t_mismatch();
    for (int k = 0; k < NPE; k++) qArr[k] = 0;
    loadQuery();
    for (int k = 0; k < 9; k++) dbArr[k] = (k == 4) ? 1 : 0;
    runCheck("R3 one mismatch costs 1", 9, 1'b0, 7);
    for (int k = 0; k < 16; k++) dbArr[k] = 1;
    runCheck("R5 no overlap", 16, 1'b0, 0);
  endtask

  task automatic t_gaps();
    setPeriodicQuery();
    for (int k = 0; k < 16; k++) dbArr[k] = qArr[k];
    dbArr[16] = 4;
    for (int k = 16; k < NPE; k++) dbArr[k+1] = qArr[k];
    runCheck("R4 single gap open", NPE + 1, 1'b0, 22);
    for (int k = 0; k < 16; k++) dbArr[k] = qArr[k];
    dbArr[16] = 4; dbArr[17] = 4;
    for (int k = 16; k < NPE; k++) dbArr[k+2] = qArr[k];
    runCheck("R4 gap extension", NPE + 2, 1'b0, 19);
  endtask

  task automatic t_reload();
    for (int k = 0; k < NPE; k++) qArr[k] = 0;
    loadQuery();
    writeOne(5, 1);
    for (int k = 0; k < NPE; k++) dbArr[k] = 0;
    runCheck("R2 query symbol rewrite", NPE, 1'b0, 30);
  endtask

  task automatic t_stall();
    for (int k = 0; k < NPE; k++) qArr[k] = $urandom_range(0, 3);
    loadQuery();
    for (int k = 0; k < 40; k++)
      dbArr[k] = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 4) : qArr[(k + 3) % NPE];
    runCheck("R7 stalled stream", 40, 1'b1, -1);
  endtask

  task automatic t_independent();
    setPeriodicQuery();
    for (int k = 0; k < NPE; k++) dbArr[k] = qArr[k];
    runCheck("R10 high sequence", NPE, 1'b0, 32);
    for (int k = 0; k < 10; k++) dbArr[k] = 4;
    runCheck("R10 following sequence", 10, 1'b0, 0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 10; n++) begin
      int len = $urandom_range(1, MAXDB);
      for (int k = 0; k < NPE; k++) qArr[k] = ($urandom_range(0, 9) == 0) ? 4 : $urandom_range(0, 3);
      loadQuery();
      for (int k = 0; k < len; k++) begin
        if (n % 2 == 0) dbArr[k] = $urandom_range(0, 4);
        else dbArr[k] = ($urandom_range(0, 4) == 0) ? $urandom_range(0, 3) : qArr[(k + n) % NPE];
      end
      runCheck("R6 random sequence", len, n[2], -1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=hang expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_wildcard();
    t_mismatch();
    t_gaps();
    t_reload();
    t_stall();
    t_independent();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule